// File: doc/BRIEF.md
# Shared-Bus 8-bit Microcoded Processor

This block is a small teaching-grade processor in which every register transfer goes over a single 8-bit bus. The bus has exactly one driver in each clock cycle. The datapath holds an accumulator, a second operand register, an instruction register, a 4-bit program counter and a memory address register. It also has a 16-byte memory, an add/subtract unit with a carry/zero flag register, and an output register. A control unit walks through five microsteps per instruction. In each step it looks up a control word in a table indexed by opcode, step number and the stored flags, and that word sets which unit drives the bus and which units load from it.

A program is written into memory through the preload port, normally while reset is held. After reset is released, execution starts at address 0. Every value the program emits appears on the output value port, together with a one-cycle strobe. The halt output rises when the program reaches its stop instruction.

Top module: `bus_cpu8`

## Requirements
- R1: While reset is high, out_val is 0, out_load is 0 and halted is 0. After reset is released, the first instruction is fetched from address 0.
- R2: An instruction byte holds the opcode in bits 7:4 and an operand (address or immediate) in bits 3:0. Every instruction takes five cycles. The first two cycles of every instruction fetch the byte at the program counter and advance the counter by one, wrapping at 16.
- R3: The opcode encodings are as follows. 1 (LDA) loads the accumulator from memory[operand]. 5 (LDI) loads the accumulator with the zero-extended operand. 4 (STA) writes the accumulator into memory[operand], and a later LDA of that address returns the stored value.
- R4: Opcode 2 (ADD) sets A to A + memory[operand] mod 256. Opcode 3 (SUB) sets A to A - memory[operand] mod 256, computed as A + ~B + 1.
- R5: Only ADD and SUB update the flags. C takes the ninth bit of the 9-bit sum (for SUB, C=1 means no borrow) and Z is set when the 8-bit result is 0. Every other opcode leaves the flags unchanged.
- R6: Opcode 6 (JMP) loads the program counter with the operand. Opcode 7 (JC) does the same only if C=1, and opcode 8 (JZ) only if Z=1. Otherwise execution falls through to the next address.
- R7: Opcode 14 (OUT) copies A into out_val. out_load is high for exactly the one cycle in which the new value first appears, and out_val does not change at any other time.
- R8: Opcode 15 (HLT) raises halted in its third cycle. halted then stays high until reset, and no further output occurs.
- R9: In every cycle, at most one unit drives the internal bus.
- R10: When pre_we is high, pre_data is written to memory[pre_addr] on the clock edge, including while reset is held.
- R11: Opcode 0 (NOP) changes no architectural state other than the program counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pre_we | input | 1 | Memory preload write enable |
| pre_addr | input | 4 | Memory preload address |
| pre_data | input | 8 | Memory preload data |
| halted | output | 1 | High once a HLT instruction has been reached |
| out_val | output | 8 | Output register value |
| out_load | output | 1 | One-cycle strobe when out_val takes a new value |

## Verification
Three programs are run against an instruction-level model in the bench, and the model's outputs are compared with the design's in every cycle. The first program is a Fibonacci loop that uses ADD, STA and JMP and ends on a taken JC at the first 8-bit carry. It shows whether the add path, carry and looping are right over a long run. The second program produces a zero result through SUB, checks that LDI leaves the flags alone so that a JZ is still taken, and then takes a borrow followed by an overflowing ADD. This tells the two flag bits and their update rules apart. The third program round-trips a value through memory across a NOP and halts before a trailing OUT, which shows that NOP changes no state and that the halt is final.

// File: rtl/bus_cpu8_pkg.sv
package bus_cpu8_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 4;
    localparam int OP_W     = DATA_W - ADDR_W;
    localparam int N_STEPS  = 5;
    localparam int STEP_W   = $clog2(N_STEPS);
    localparam int UC_IDX_W = OP_W + STEP_W + 2;
    localparam int UC_DEPTH = 1 << UC_IDX_W;

    typedef enum logic [OP_W-1:0] {
        OP_NOP = 4'h0,
        OP_LDA = 4'h1,
        OP_ADD = 4'h2,
        OP_SUB = 4'h3,
        OP_STA = 4'h4,
        OP_LDI = 4'h5,
        OP_JMP = 4'h6,
        OP_JC  = 4'h7,
        OP_JZ  = 4'h8,
        OP_OUT = 4'hE,
        OP_HLT = 4'hF
    } opcode_e;

    typedef struct packed {
        logic carry;
        logic zero;
    } flags_t;

    typedef struct packed {
        logic pc_drv;
        logic pc_inc;
        logic pc_ld;
        logic mar_ld;
        logic mem_drv;
        logic mem_wr;
        logic ir_drv;
        logic ir_ld;
        logic a_ld;
        logic a_drv;
        logic b_ld;
        logic alu_drv;
        logic alu_sub;
        logic flg_ld;
        logic out_ld;
        logic stop;
    } ctrl_word_t;

    // Control word for one (opcode, step, carry, zero) combination.
    function automatic ctrl_word_t uc_entry(logic [UC_IDX_W-1:0] idx);
        ctrl_word_t w;
        logic [OP_W-1:0]   op;
        logic [STEP_W-1:0] st;
        logic              c;
        logic              z;
        op = idx[UC_IDX_W-1 -: OP_W];
        st = idx[STEP_W+1 -: STEP_W];
        c  = idx[1];
        z  = idx[0];
        w  = '0;
        if (st == 0) begin
            w.pc_drv = 1'b1; w.mar_ld = 1'b1;
        end else if (st == 1) begin
            w.mem_drv = 1'b1; w.ir_ld = 1'b1; w.pc_inc = 1'b1;
        end else begin
            case (op)
                OP_LDA: if (st == 2) begin w.ir_drv = 1'b1; w.mar_ld = 1'b1; end
                        else if (st == 3) begin w.mem_drv = 1'b1; w.a_ld = 1'b1; end
                OP_ADD, OP_SUB: begin
                        if (st == 2) begin w.ir_drv = 1'b1; w.mar_ld = 1'b1; end
                        else if (st == 3) begin w.mem_drv = 1'b1; w.b_ld = 1'b1; end
                        else if (st == 4) begin
                            w.alu_drv = 1'b1; w.a_ld = 1'b1; w.flg_ld = 1'b1;
                            w.alu_sub = (op == OP_SUB);
                        end
                    end
                OP_STA: if (st == 2) begin w.ir_drv = 1'b1; w.mar_ld = 1'b1; end
                        else if (st == 3) begin w.a_drv = 1'b1; w.mem_wr = 1'b1; end
                OP_LDI: if (st == 2) begin w.ir_drv = 1'b1; w.a_ld = 1'b1; end
                OP_JMP: if (st == 2) begin w.ir_drv = 1'b1; w.pc_ld = 1'b1; end
                OP_JC:  if (st == 2 && c) begin w.ir_drv = 1'b1; w.pc_ld = 1'b1; end
                OP_JZ:  if (st == 2 && z) begin w.ir_drv = 1'b1; w.pc_ld = 1'b1; end
                OP_OUT: if (st == 2) begin w.a_drv = 1'b1; w.out_ld = 1'b1; end
                OP_HLT: if (st == 2) w.stop = 1'b1;
                default: ;
            endcase
        end
        return w;
    endfunction

endpackage

// File: rtl/bus_cpu8_mem.sv
module bus_cpu8_mem
    import bus_cpu8_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          pre_we,
    input  logic [AW-1:0] pre_addr,
    input  logic [DW-1:0] pre_data,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (pre_we)
            cells[pre_addr] <= pre_data;
        else if (wr)
            cells[addr] <= wdata;
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/bus_cpu8_alu.sv
module bus_cpu8_alu
    import bus_cpu8_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sub,
    output logic [DW-1:0] result,
    output flags_t        flags_nxt
);
    logic [DW:0]   sum;
    logic [DW-1:0] b_eff;

    always_comb begin
        b_eff           = sub ? ~b : b;
        sum             = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, sub};
        result          = sum[DW-1:0];
        flags_nxt.carry = sum[DW];
        flags_nxt.zero  = (sum[DW-1:0] == '0);
    end
endmodule

// File: rtl/bus_cpu8_ctrl.sv
module bus_cpu8_ctrl
    import bus_cpu8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   opcode,
    input  flags_t            flags,
    output logic [STEP_W-1:0] step,
    output ctrl_word_t        cw
);
    localparam logic [STEP_W-1:0] LAST = STEP_W'(N_STEPS - 1);

    ctrl_word_t uc_rom [UC_DEPTH];

    for (genvar i = 0; i < UC_DEPTH; i++) begin : g_rom
        assign uc_rom[i] = uc_entry(UC_IDX_W'(i));
    end

    assign cw = uc_rom[{opcode, step, flags.carry, flags.zero}];

    always_ff @(posedge clk) begin
        if (rst)
            step <= '0;
        else if (!cw.stop)
            step <= (step == LAST) ? '0 : step + 1'b1;
    end
endmodule

// File: rtl/bus_cpu8.sv
module bus_cpu8
    import bus_cpu8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pre_we,
    input  logic [ADDR_W-1:0] pre_addr,
    input  logic [DATA_W-1:0] pre_data,
    output logic              halted,
    output logic [DATA_W-1:0] out_val,
    output logic              out_load
);
    ctrl_word_t        cw;
    logic [STEP_W-1:0] step;
    logic [ADDR_W-1:0] pc_q, mar_q;
    logic [DATA_W-1:0] ir_q, a_q, b_q, out_q;
    logic              out_ld_q;
    flags_t            flags_q, flags_nxt;
    logic [DATA_W-1:0] bus, mem_rdata, alu_res;
    logic [4:0]        drv_vec;
    logic              flg_we;

    bus_cpu8_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .opcode (ir_q[DATA_W-1 -: OP_W]),
        .flags  (flags_q),
        .step   (step),
        .cw     (cw)
    );

    bus_cpu8_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
        .clk      (clk),
        .pre_we   (pre_we),
        .pre_addr (pre_addr),
        .pre_data (pre_data),
        .wr       (cw.mem_wr),
        .addr     (mar_q),
        .wdata    (bus),
        .rdata    (mem_rdata)
    );

    bus_cpu8_alu #(.DW(DATA_W)) u_alu (
        .a         (a_q),
        .b         (b_q),
        .sub       (cw.alu_sub),
        .result    (alu_res),
        .flags_nxt (flags_nxt)
    );

    assign drv_vec = {cw.pc_drv, cw.mem_drv, cw.ir_drv, cw.a_drv, cw.alu_drv};
    assign flg_we  = cw.flg_ld;

    always_comb begin
        bus = '0;
        if (cw.pc_drv)       bus = DATA_W'(pc_q);
        else if (cw.mem_drv) bus = mem_rdata;
        else if (cw.ir_drv)  bus = DATA_W'(ir_q[ADDR_W-1:0]);
        else if (cw.a_drv)   bus = a_q;
        else if (cw.alu_drv) bus = alu_res;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= '0;
            mar_q    <= '0;
            ir_q     <= '0;
            a_q      <= '0;
            b_q      <= '0;
            out_q    <= '0;
            out_ld_q <= 1'b0;
            flags_q  <= '0;
        end else begin
            if (cw.pc_ld)       pc_q <= bus[ADDR_W-1:0];
            else if (cw.pc_inc) pc_q <= pc_q + 1'b1;
            if (cw.mar_ld) mar_q   <= bus[ADDR_W-1:0];
            if (cw.ir_ld)  ir_q    <= bus;
            if (cw.a_ld)   a_q     <= bus;
            if (cw.b_ld)   b_q     <= bus;
            if (cw.flg_ld) flags_q <= flags_nxt;
            if (cw.out_ld) out_q   <= bus;
            out_ld_q <= cw.out_ld;
        end
    end

    assign halted   = cw.stop;
    assign out_val  = out_q;
    assign out_load = out_ld_q;
endmodule

// File: rtl/bus_cpu8_chk.sv
module bus_cpu8_chk
    import bus_cpu8_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [4:0]        drv_vec,
    input logic [STEP_W-1:0] step,
    input logic              halted,
    input logic [DATA_W-1:0] out_val,
    input logic              out_load,
    input logic              flg_we,
    input flags_t            flags_q
);
    localparam logic [STEP_W-1:0] LAST = STEP_W'(N_STEPS - 1);

    // R9
    one_driver_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(drv_vec));

    // R2
    step_range_chk: assert property (@(posedge clk) disable iff (rst)
        step <= LAST);

    // R2
    step_seq_chk: assert property (@(posedge clk) disable iff (rst)
        (!halted && step != LAST) |=> step == $past(step) + 1'b1);

    // R7
    out_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_load |=> !out_load);

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !out_load |-> $stable(out_val));

    // R8
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    // R5
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !flg_we |=> $stable(flags_q));
endmodule

bind bus_cpu8 bus_cpu8_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .drv_vec  (drv_vec),
    .step     (step),
    .halted   (halted),
    .out_val  (out_val),
    .out_load (out_load),
    .flg_we   (flg_we),
    .flags_q  (flags_q)
);

// File: tb/sim_bus_cpu8.sv
`timescale 1ns/1ps
module sim_bus_cpu8;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pre_we = 1'b0;
    logic [3:0] pre_addr = '0;
    logic [7:0] pre_data = '0;
    logic       halted;
    logic [7:0] out_val;
    logic       out_load;

    bus_cpu8 u0 (
        .clk(clk), .rst(rst), .pre_we(pre_we), .pre_addr(pre_addr),
        .pre_data(pre_data), .halted(halted), .out_val(out_val),
        .out_load(out_load)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] prog [16];
    int exp_q[$];
    int got_q[$];

    // instruction-level reference state
    logic [7:0] m_mem [16];
    logic [3:0] m_pc;
    logic [7:0] m_a, m_ir, m_out;
    logic       m_c, m_z, m_halt, m_load;
    int         m_step;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_pc = 0; m_a = 0; m_ir = 0; m_out = 0;
        m_c = 0; m_z = 0; m_halt = 0; m_load = 0; m_step = 0;
    endtask

    task automatic model_exec();
        logic [3:0] opr;
        logic [8:0] s;
        opr = m_ir[3:0];
        case (m_ir[7:4])
            4'h1: m_a = m_mem[opr];
            4'h2: begin s = {1'b0, m_a} + {1'b0, m_mem[opr]};
                        m_a = s[7:0]; m_c = s[8]; m_z = (s[7:0] == 0); end
            4'h3: begin s = {1'b0, m_a} + {1'b0, ~m_mem[opr]} + 9'd1;
                        m_a = s[7:0]; m_c = s[8]; m_z = (s[7:0] == 0); end
            4'h4: m_mem[opr] = m_a;
            4'h5: m_a = {4'h0, opr};
            4'h6: m_pc = opr;
            4'h7: if (m_c) m_pc = opr;
            4'h8: if (m_z) m_pc = opr;
            4'hE: begin m_out = m_a; m_load = 1; end
            default: ;
        endcase
    endtask

    always @(posedge clk) begin
        if (!rst && !done) begin
            m_load = 0;
            if (!m_halt) begin
                if (m_step == 1) begin
                    m_ir = m_mem[m_pc];
                    m_pc = m_pc + 4'd1;
                end else if (m_step == 2) begin
                    model_exec();
                end
                if (m_step == 1 && m_ir[7:4] == 4'hF) begin
                    m_halt = 1; m_step = 2;
                end else begin
                    m_step = (m_step == 4) ? 0 : m_step + 1;
                end
            end
        end
    end

    // cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R7 out_val", out_val, m_out);
            check("R7 out_load", out_load, m_load);
            check("R8 halted", halted, m_halt);
            if (out_load) got_q.push_back(out_val);
        end
    end

    task automatic run_prog(string name, int max_cycles);
        int n;
        rst = 1'b1;
        model_reset();
        got_q.delete();
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            pre_we = 1'b1; pre_addr = 4'(i); pre_data = prog[i];
            m_mem[i] = prog[i];
        end
        @(negedge clk);
        pre_we = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 reset out_val", out_val, 0);
        check("R1 reset out_load", out_load, 0);
        check("R1 reset halted", halted, 0);
        rst = 1'b0;
        n = 0;
        while (!halted && n < max_cycles) begin
            @(negedge clk);
            n++;
        end
        check({"R8 program reached halt: ", name}, halted, 1);
        repeat (20) @(negedge clk);
        check({"R8 halt holds: ", name}, halted, 1);
        check({"R7 output count: ", name}, got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            check({"R4 output value: ", name}, got_q[i], exp_q[i]);
    endtask

    initial begin
        // Program 1: Fibonacci until carry (R2, R3, R4, R6 JC taken, JMP)
        prog = '{8'h51, 8'h4F, 8'hE0, 8'h2E, 8'h7C, 8'h4E, 8'hE0, 8'h2F,
                 8'h7C, 8'h4F, 8'hE0, 8'h63, 8'hF0, 8'h00, 8'h00, 8'h00};
        exp_q = '{1, 1, 2, 3, 5, 8, 13, 21, 34, 55, 89, 144, 233};
        run_prog("fibonacci R6", 3000);

        // Program 2: flags, SUB, JZ taken, JC not taken (R5, R6, R4)
        prog = '{8'h55, 8'h3F, 8'h57, 8'h85, 8'hE0, 8'hE0, 8'h3E, 8'hE0,
                 8'h7A, 8'h1D, 8'h2D, 8'hE0, 8'hF0, 8'h80, 8'h09, 8'h05};
        exp_q = '{7, 254, 0};
        run_prog("flags R5", 1000);

        // Program 3: memory round trip across NOP, nothing after HLT (R3, R11, R8, R10)
        prog = '{8'h53, 8'h4F, 8'h50, 8'h00, 8'h1F, 8'hE0, 8'hF0, 8'hE0,
                 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h11};
        exp_q = '{3};
        run_prog("nop R11 store R3 preload R10", 1000);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule